// File: doc/BRIEF.md
# Timer counter with clock-source control

This block is a 16-bit up-counting timer core with a byte-wide control register. The timer counts only in the system clock domain. Each possible time base is turned into a one-cycle count enable. These time bases are the system clock divided by 4, the system clock itself, a high-speed tick enable divided by 16 or 64, a low-speed tick enable, and a rising or falling edge seen on an external pin.

Software writes the control register to pick the time base, to turn the timer on or off, and to pause or resume counting. Turning the timer on clears the count. Turning it off keeps the count. When the output pin is used by one of the waveform modes, turning the timer on also loads the pin with a programmed initial level.

The count can be read as two bytes. Reading the low byte captures the high byte, so a low-then-high pair of reads always forms one consistent 16-bit value.

Top module: `tmr16_core`

## Requirements
- R1: Address 0 is the control register. Bit 7 is pause, bits 6:4 are the clock select code, bit 3 is the on bit, and bits 2:0 read back as 0 whatever was written. Address 3 reads as 0.
- R2: After reset, the control register reads 0x00, the count is 0, and both pin_o and ovf_o are 0.
- R3: While on and not paused, the count advances by one per enable of the selected internal base. Code 000 is the system clock divided by 4. Code 001 is every system clock. Code 010 is every 16th cycle with hi_tick high. Code 011 is every 64th cycle with hi_tick high.
- R4: Codes 100 and 101 both count each cycle with lo_tick high, and they ignore hi_tick.
- R5: Code 110 counts rising edges of ext_pin and code 111 counts falling edges. The count changes on the third rising clock edge after the pin changes.
- R6: With pause set, the count holds its value. Clearing pause resumes counting from the held value. A control write takes effect after its own clock edge.
- R7: A control write that takes the on bit from 0 to 1 clears the count. A write that keeps the on bit at 1 does not clear it.
- R8: A control write that takes the on bit from 1 to 0 stops counting, and the count keeps its value.
- R9: On a 0-to-1 change of the on bit, pin_o loads init_lvl when wave_mode is 00 (compare output) or 10 (PWM or single pulse). With wave_mode 01 or 11, pin_o does not change.
- R10: The count wraps from 0xFFFF to 0x0000. ovf_o is high for exactly the one cycle in which the count shows that wrapped 0.
- R11: Address 1 reads count bits 7:0. A read at address 1 captures count bits 15:8 at that clock edge, and address 2 returns the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hi_tick | input | 1 | high-speed time base enable |
| lo_tick | input | 1 | low-speed time base enable |
| ext_pin | input | 1 | external clock pin, asynchronous |
| wave_mode | input | 2 | 00 compare, 01 capture, 10 PWM/single pulse, 11 plain count |
| init_lvl | input | 1 | initial level for pin_o |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 2 | register address |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, combinational from addr |
| count_o | output | 16 | current count |
| ovf_o | output | 1 | one-cycle wrap pulse |
| pin_o | output | 1 | output pin level |

## Verification
Each clock code is run over a window that is a whole multiple of its divider, so the expected number of increments is exact whatever the prescaler phase. A wrong mux entry, or a divider that is off by one, changes that number. The polarity of the external edge is checked at the exact third edge after the pin changes, so swapped codes 110 and 111 or a missing synchroniser stage show up there.

Rewriting the control register while the timer is on must not clear the count. The write edge that sets pause must still count. A design that clears on the level of the on bit, or that applies control writes early, fails there.

The read of 0x00FF taken while the count rolls to 0x0100 catches a high byte that is sampled late. The run to 0xFFFF checks that the count wraps to 0 and that the overflow pulse lasts exactly one cycle.

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int SYS_DIV  = 4,
  parameter int HI_DIV_A = 16,
  parameter int HI_DIV_B = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hi_tick,
  input  logic        lo_tick,
  input  logic        ext_pin,
  input  logic [1:0]  wave_mode,
  input  logic        init_lvl,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [15:0] count_o,
  output logic        ovf_o,
  output logic        pin_o
);
  localparam int SD_W = $clog2(SYS_DIV);
  localparam int HA_W = $clog2(HI_DIV_A);
  localparam int HB_W = $clog2(HI_DIV_B);

  logic [7:0]      ctrl_q;
  logic [SD_W-1:0] sdiv_q;
  logic [HB_W-1:0] hdiv_q;
  logic [2:0]      ext_s;
  logic [7:0]      hold_q;
  logic            tick;

  wire       pause   = ctrl_q[7];
  wire [2:0] sel     = ctrl_q[6:4];
  wire       on      = ctrl_q[3];
  wire       ctrl_wr = wr_en && (addr == 2'd0);
  wire       turn_on = ctrl_wr && wdata[3] && !on;
  wire       run     = on && !pause;
  wire       step    = run && tick;
  wire       drives_pin = (wave_mode == 2'b00) || (wave_mode == 2'b10);

  wire sys_en  = (sdiv_q == SD_W'(SYS_DIV - 1));
  wire hia_en  = hi_tick && (hdiv_q[HA_W-1:0] == {HA_W{1'b1}});
  wire hib_en  = hi_tick && (hdiv_q == {HB_W{1'b1}});
  wire ext_up  = ext_s[1] && !ext_s[2];
  wire ext_dn  = !ext_s[1] && ext_s[2];

  always_comb begin
    case (sel)
      3'd0:    tick = sys_en;
      3'd1:    tick = 1'b1;
      3'd2:    tick = hia_en;
      3'd3:    tick = hib_en;
      3'd6:    tick = ext_up;
      3'd7:    tick = ext_dn;
      default: tick = lo_tick;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sdiv_q <= '0;
      hdiv_q <= '0;
      ext_s  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= {wdata[7:3], 3'b000};
      sdiv_q <= sdiv_q + 1'b1;
      if (hi_tick) hdiv_q <= hdiv_q + 1'b1;
      ext_s <= {ext_s[1:0], ext_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      ovf_o <= !turn_on && step && (&count_o);
      if (turn_on)   count_o <= '0;
      else if (step) count_o <= count_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (turn_on && drives_pin) pin_o <= init_lvl;
      if (rd_en && addr == 2'd1) hold_q <= count_o[15:8];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = ctrl_q;
      2'd1:    rdata = count_o[7:0];
      2'd2:    rdata = hold_q;
      default: rdata = 8'h00;
    endcase
  end
endmodule

module tmr16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [7:0]  ctrl,
  input logic [15:0] count_o,
  input logic        ovf_o,
  input logic        pin_o
);
  wire wr_ctrl = wr_en && addr == 2'd0;
  wire rise_on = wr_ctrl && wdata[3] && !ctrl[3];

  assert_ctrl_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd0 |-> rdata[2:0] == 3'b000);

  assert_pause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] || !ctrl[3]) && !wr_ctrl |=> $stable(count_o));

  assert_on_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_on |=> count_o == 16'h0000);

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_on |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 16'd1));

  assert_ovf_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> count_o == 16'h0000);

  assert_pin_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_on |=> $stable(pin_o));
endmodule

bind tmr16_core tmr16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .ctrl(ctrl_q), .count_o(count_o), .ovf_o(ovf_o), .pin_o(pin_o)
);

// File: tb/tb_tmr16_core.sv
`timescale 1ns/1ps
module tb_tmr16_core;
  logic clk = 0, rst_n = 0;
  logic hi_tick = 0, lo_tick = 0, ext_pin = 0, init_lvl = 0;
  logic [1:0] wave_mode = 2'b11;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [15:0] count_o;
  logic ovf_o, pin_o;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] rv;

  tmr16_core dut (.*);

  always #5 clk = ~clk;

  localparam int NV = 8;
  localparam logic [2:0] V_SEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd4, 3'd2};
  localparam logic       V_HI  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic       V_LO  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int         V_N   [NV] = '{40, 40, 64, 128, 30, 30, 30, 64};
  localparam int         V_EXP [NV] = '{10, 40, 4, 2, 30, 30, 0, 0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 0; addr = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd0, rv);
    chk("R2 ctrl", rv, 8'h00);
    chk("R2 count", count_o, 0);
    chk("R2 pin", pin_o, 0);
    chk("R2 ovf", ovf_o, 0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 8'h00);
      hi_tick = V_HI[i]; lo_tick = V_LO[i];
      wr(2'd0, {1'b0, V_SEL[i], 1'b1, 3'b000});
      run(V_N[i]);
      chk(V_SEL[i] >= 3'd4 ? "R4 vector" : "R3 vector", count_o, V_EXP[i]);
    end
    hi_tick = 0; lo_tick = 0;

    wr(2'd0, 8'hFF);
    rd(2'd0, rv);
    chk("R1 readback", rv, 8'hF8);
    rd(2'd3, rv);
    chk("R1 addr3", rv, 8'h00);

    wr(2'd0, 8'h00);
    wr(2'd0, 8'h18);
    run(10);
    chk("R6 running", count_o, 10);
    wr(2'd0, 8'h98);
    chk("R6 pause write edge counts", count_o, 11);
    run(10);
    chk("R6 paused hold", count_o, 11);
    wr(2'd0, 8'h18);
    run(5);
    chk("R6 resume", count_o, 16);
    wr(2'd0, 8'h18);
    chk("R7 rewrite keeps", count_o, 17);
    wr(2'd0, 8'h10);
    run(5);
    chk("R8 off keeps", count_o, 18);
    wr(2'd0, 8'h18);
    chk("R7 on clears", count_o, 0);

    wr(2'd0, 8'h00);
    wr(2'd0, 8'h68);
    run(5);
    ext_pin = 1;
    run(2);
    chk("R5 rise before latency", count_o, 0);
    run(1);
    chk("R5 rise counted", count_o, 1);
    ext_pin = 0;
    run(5);
    chk("R5 fall ignored", count_o, 1);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h78);
    run(3);
    ext_pin = 1;
    run(5);
    chk("R5 rise ignored", count_o, 0);
    ext_pin = 0;
    run(2);
    chk("R5 fall before latency", count_o, 0);
    run(1);
    chk("R5 fall counted", count_o, 1);

    wr(2'd0, 8'h00);
    init_lvl = 1; wave_mode = 2'b11;
    wr(2'd0, 8'h08);
    chk("R9 plain mode no load", pin_o, 0);
    wr(2'd0, 8'h00);
    wave_mode = 2'b01;
    wr(2'd0, 8'h08);
    chk("R9 capture mode no load", pin_o, 0);
    wr(2'd0, 8'h00);
    wave_mode = 2'b00;
    wr(2'd0, 8'h08);
    chk("R9 compare load", pin_o, 1);
    wr(2'd0, 8'h08);
    init_lvl = 0; wave_mode = 2'b10;
    wr(2'd0, 8'h08);
    chk("R9 no reload while on", pin_o, 1);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h08);
    chk("R9 pwm load", pin_o, 0);

    wr(2'd0, 8'h00);
    wr(2'd0, 8'h18);
    run(255);
    rd(2'd1, rv);
    chk("R11 low byte", rv, 8'hFF);
    rd(2'd2, rv);
    chk("R11 latched high", rv, 8'h00);
    chk("R11 live count", count_o, 16'h0101);

    wr(2'd0, 8'h00);
    wr(2'd0, 8'h18);
    run(65535);
    chk("R10 at max", count_o, 16'hFFFF);
    chk("R10 no ovf yet", ovf_o, 0);
    run(1);
    chk("R10 wrap", count_o, 16'h0000);
    chk("R10 ovf pulse", ovf_o, 1);
    run(1);
    chk("R10 after wrap", count_o, 16'h0001);
    chk("R10 ovf one cycle", ovf_o, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule